// File: doc/BRIEF.md
# Block-Out Streaming Engine

This block is the streaming output stage of an accelerator's instruction engine. When a block-out instruction is offered to it, the engine copies a run of 32-bit words from the accelerator's internal register file to a one-way output port. The run starts at a source index taken from the instruction. Its length is taken from a length value sampled at the moment the instruction is accepted. Each word waits on the output until the consumer acknowledges it. The instruction's 10-bit tag is driven on a separate tag output for the whole run.

The register file is outside the block. It answers a read request one cycle later. The engine tracks requests in flight and keeps a two-word output queue, so this latency does not slow the stream. The engine raises a one-cycle completion pulse after the last word is taken. The surrounding sequencer uses that pulse to step its program counter.

Top module: `blkout_engine`

## Requirements
- R1: During and right after reset, out_valid, done and rf_rd_en are low.
- R2: An instruction is accepted only when instr_valid is high, bits [31:26] equal 6'h0F, and the engine is idle. Any other opcode produces no read, no word and no done pulse.
- R3: From the cycle after acceptance until the run ends, out_tag equals instruction bits [22:13] and does not change.
- R4: Word i of a run (i from 0) is the register-file word at address (instr[11:0] + i) modulo 4096, where bits [11:10] select the bank and bits [9:0] give the offset. Words leave in order. Bit 12 and bits [25:23] have no effect.
- R5: Exactly xfer_len words, sampled at acceptance, are handed over, and exactly that many register-file reads are issued.
- R6: out_valid first rises after the second rising edge that follows the acceptance edge.
- R7: While out_valid is high and out_ack is low, out_valid stays high and out_data holds its value on the next cycle.
- R8: out_ack is ignored while out_valid is low, so no word is consumed.
- R9: With out_ack held high, consecutive words are handed over one per cycle, with no idle cycle between the first and last word.
- R10: In the cycle after the edge that takes the last word, out_valid is low and done is high. done is high for exactly one cycle.
- R11: A length of zero issues no reads and no words. done pulses in the cycle after the acceptance edge.
- R12: An instruction offered while a run is in progress is ignored: the tag, the word count and the data of the run are unchanged, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | An instruction word is offered this cycle |
| instr_word | input | 32 | Instruction: opcode [31:26], tag [22:13], source index [11:0] |
| xfer_len | input | LEN_W (10) | Word count, sampled on acceptance |
| rf_rd_en | output | 1 | Register-file read request |
| rf_rd_addr | output | 12 | Register-file read address |
| rf_rd_data | input | WORD_W (32) | Read data, valid one cycle after the request |
| out_data | output | WORD_W (32) | Streamed word |
| out_valid | output | 1 | out_data holds a word that has not been taken |
| out_tag | output | 10 | Tag of the current run |
| out_ack | input | 1 | Consumer takes the word at the next rising edge |
| done | output | 1 | One-cycle pulse after the run completes |

## Verification
All timing is counted from the acceptance edge. The tag is due one edge later. The first word is due two edges later. The completion pulse is due one edge after the edge that takes the last word, and a zero-length run pulses one edge after acceptance. The bench drives and samples on the falling edge, indexes each cycle from acceptance, and tests out_valid at exactly cycles 2 and 3. Throughput is measured as the distance between the first valid cycle and the last acknowledge. The bench sweeps lengths, source indices (including a wrap past 4095) and four acknowledge patterns, one of which holds the acknowledge high before any word is valid.

// File: rtl/blkout_pkg.sv
// Shared constants and types for the block-out streaming engine.
// Assumes the fixed 32-bit instruction layout: opcode [31:26], tag [22:13],
// source index [11:0] (bank [11:10], offset [9:0]).
package blkout_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int OPC_LSB = 26;
    localparam int TAG_W   = 10;
    localparam int TAG_LSB = 13;
    localparam int SEL_W   = 2;
    localparam int OFF_W   = 10;
    localparam int SRC_W   = SEL_W + OFF_W;
    localparam int SRC_LSB = 0;
    localparam logic [OPC_W-1:0] OPC_BLKOUT = 6'h0F;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SRC_W-1:0] src;
    } blkout_cmd_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } run_state_t;
endpackage

// File: rtl/blkout_decode.sv
// Instruction decoder: flags the block-out opcode and pulls the tag and
// source index out of the instruction word. Purely combinational.
module blkout_decode
    import blkout_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               is_blkout,
    output blkout_cmd_t        cmd
);
    logic unused_fields;

    // Split the instruction into opcode match and command fields.
    always_comb begin
        is_blkout = (instr[OPC_LSB +: OPC_W] == OPC_BLKOUT);
        cmd.tag   = instr[TAG_LSB +: TAG_W];
        cmd.src   = instr[SRC_LSB +: SRC_W];
    end

    assign unused_fields = ^{instr[25:23], instr[12]};
endmodule

// File: rtl/blkout_fetch.sv
// Read issuer: walks the register file from a base index for a given count.
// It issues a read only when the caller reports a free slot downstream.
// Assumes load arrives only while no reads are pending.
module blkout_fetch #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              slot_free,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;

    assign rd_en   = (left_q != '0) && slot_free;
    assign rd_addr = addr_q;

    // Load the run on acceptance, then step address and count per read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= base;
            left_q <= len;
        end else if (rd_en) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/blkout_outq.sv
// Two-entry output queue: a head register that drives the port and a skid
// register behind it. Assumes the caller never lands a word while both
// entries are full and the head is not leaving.
module blkout_outq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         ack,
    output logic         head_valid,
    output logic [W-1:0] head_data,
    output logic         skid_valid
);
    logic [W-1:0] skid_q;
    logic         pop;

    assign pop = head_valid && ack;

    // Advance the head from the skid or from the arriving word, else fill the skid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_valid <= 1'b0;
            head_data  <= '0;
            skid_valid <= 1'b0;
            skid_q     <= '0;
        end else if (!head_valid || pop) begin
            if (skid_valid) begin
                head_valid <= 1'b1;
                head_data  <= skid_q;
                skid_valid <= in_valid;
                if (in_valid) skid_q <= in_data;
            end else begin
                head_valid <= in_valid;
                if (in_valid) head_data <= in_data;
            end
        end else if (in_valid) begin
            skid_valid <= 1'b1;
            skid_q     <= in_data;
        end
    end
endmodule

// File: rtl/blkout_engine.sv
// Block-out streaming engine top. It accepts a block-out instruction while
// idle, drives its tag, and streams xfer_len register-file words through a
// valid/acknowledge port. done pulses once after the final word is taken.
// Assumes the register file returns data one cycle after rf_rd_en.
module blkout_engine
    import blkout_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [LEN_W-1:0]   xfer_len,
    output logic               rf_rd_en,
    output logic [SRC_W-1:0]   rf_rd_addr,
    input  logic [WORD_W-1:0]  rf_rd_data,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_valid,
    output logic [TAG_W-1:0]   out_tag,
    input  logic               out_ack,
    output logic               done
);
    localparam int QDEPTH = 2;
    localparam int OCC_W  = 2;

    run_state_t          state_q;
    blkout_cmd_t         cmd;
    logic                is_blkout;
    logic                accept;
    logic                pop;
    logic                last_pop;
    logic                inflight_q;
    logic                skid_valid;
    logic                slot_free;
    logic [OCC_W-1:0]    occ_next;
    logic [LEN_W-1:0]    words_left_q;

    blkout_decode u_dec (
        .instr     (instr_word),
        .is_blkout (is_blkout),
        .cmd       (cmd)
    );

    assign accept   = instr_valid && is_blkout && (state_q == ST_IDLE);
    assign pop      = out_valid && out_ack;
    assign last_pop = pop && (words_left_q == LEN_W'(1));

    // Count queue entries plus the read in flight, less the word leaving now.
    always_comb begin
        occ_next  = {1'b0, out_valid} + {1'b0, skid_valid} + {1'b0, inflight_q} - {1'b0, pop};
        slot_free = (occ_next < OCC_W'(QDEPTH));
    end

    blkout_fetch #(
        .ADDR_W (SRC_W),
        .LEN_W  (LEN_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .base      (cmd.src),
        .len       (xfer_len),
        .slot_free (slot_free),
        .rd_en     (rf_rd_en),
        .rd_addr   (rf_rd_addr)
    );

    // Remember that a read was issued so its data is captured next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= 1'b0;
        else        inflight_q <= rf_rd_en;
    end

    blkout_outq #(
        .W (WORD_W)
    ) u_outq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (inflight_q),
        .in_data    (rf_rd_data),
        .ack        (out_ack),
        .head_valid (out_valid),
        .head_data  (out_data),
        .skid_valid (skid_valid)
    );

    // Run control: accept, count words handed over, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            words_left_q <= '0;
            out_tag      <= '0;
            done         <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                out_tag      <= cmd.tag;
                words_left_q <= xfer_len;
                if (xfer_len == '0) done    <= 1'b1;
                else                state_q <= ST_RUN;
            end else if (pop) begin
                words_left_q <= words_left_q - 1'b1;
                if (last_pop) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/blkout_checker.sv
// Property checker for the block-out engine, attached by bind.
// Observes ports plus the acceptance strobe and the remaining word count.
module blkout_checker
    import blkout_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ack,
    input logic [WORD_W-1:0] out_data,
    input logic [TAG_W-1:0]  out_tag,
    input logic              done,
    input logic              rf_rd_en,
    input logic              accept,
    input logic [LEN_W-1:0]  words_left
);
    assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));

    assert_tag_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $stable(out_tag));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_no_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    assert_accept_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !out_valid);

    assert_read_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> (words_left != '0));
endmodule

bind blkout_engine blkout_checker #(
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ack    (out_ack),
    .out_data   (out_data),
    .out_tag    (out_tag),
    .done       (done),
    .rf_rd_en   (rf_rd_en),
    .accept     (accept),
    .words_left (words_left_q)
);

// File: tb/sim_blkout_engine.sv
// Self-checking bench for the block-out engine: sweeps lengths, source
// indices and acknowledge patterns against an arithmetic register-file model.
module sim_blkout_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [9:0]  xfer_len = '0;
    logic        rf_rd_en;
    logic [11:0] rf_rd_addr;
    logic [31:0] rf_rd_data = '0;
    logic [31:0] out_data;
    logic        out_valid;
    logic [9:0]  out_tag;
    logic        out_ack = 1'b0;
    logic        done;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkout_engine u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .xfer_len    (xfer_len),
        .rf_rd_en    (rf_rd_en),
        .rf_rd_addr  (rf_rd_addr),
        .rf_rd_data  (rf_rd_data),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .out_tag     (out_tag),
        .out_ack     (out_ack),
        .done        (done)
    );

    function automatic logic [31:0] dat(input logic [11:0] a);
        return ({20'd0, a} * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [9:0] tag,
                                       input logic ib, input logic [11:0] src);
        return {op, 3'b101, tag, ib, src};
    endfunction

    function automatic bit ack_pat(input int pat, input int n);
        case (pat)
            0:       return 1'b1;
            1:       return (n % 2) == 1;
            2:       return (n % 3) == 2;
            default: return (n % 4) != 1;
        endcase
    endfunction

    // Register-file model: one cycle of read latency, junk when not read.
    always @(posedge clk) begin
        if (rf_rd_en) begin
            rf_rd_data <= dat(rf_rd_addr);
            rd_cnt     <= rd_cnt + 1;
        end else begin
            rf_rd_data <= 32'hBAD0_0BAD;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Run one transfer and check every cycle from acceptance to completion.
    task automatic run_xfer(input logic [9:0] tag, input logic [11:0] src, input int len,
                            input int pat, input bit poke);
        int got, n, first_v, last_ack, reads0;
        logic [31:0] prev;
        bit prev_stall, ackv;
        reads0 = rd_cnt;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = mk(6'h0F, tag, 1'b1, src);
        xfer_len    = 10'(len);
        out_ack     = 1'b0;
        @(negedge clk);
        instr_valid = 1'b0;
        xfer_len    = 10'd0;
        chk(out_tag == tag, "R3 tag after accept", 32'(out_tag), 32'(tag));
        chk(!out_valid, "R6 no word in cycle 1", 32'(out_valid), 0);
        got = 0; n = 1; first_v = -1; last_ack = 0; prev_stall = 0; prev = '0;
        while (got < len && n < 8 * len + 20) begin
            ackv    = ack_pat(pat, n);
            out_ack = ackv;
            if (poke && n == 4) begin
                instr_valid = 1'b1;
                instr_word  = mk(6'h0F, ~tag, 1'b0, src + 12'd100);
                xfer_len    = 10'd3;
            end else begin
                instr_valid = 1'b0;
            end
            if (n == 2) chk(!out_valid, "R6 no word in cycle 2", 32'(out_valid), 0);
            if (n == 3) chk(out_valid, "R6 word in cycle 3", 32'(out_valid), 1);
            if (done) chk(1'b0, "R10 early done", 1, 0);
            if (prev_stall) chk(out_valid && out_data == prev, "R7 hold", out_data, prev);
            if (out_valid) begin
                if (first_v < 0) first_v = n;
                chk(out_data == dat(12'(src + got)), "R4 word", out_data, dat(12'(src + got)));
                chk(out_tag == tag, "R3 tag steady", 32'(out_tag), 32'(tag));
                if (ackv) begin
                    got++;
                    last_ack = n;
                end
                prev_stall = !ackv;
                prev       = out_data;
            end else begin
                prev_stall = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        out_ack     = 1'b0;
        instr_valid = 1'b0;
        chk(got == len, "R5 word count", 32'(got), 32'(len));
        chk(!out_valid, "R10 valid drops", 32'(out_valid), 0);
        chk(done, "R10 done pulse", 32'(done), 1);
        if (pat == 0) chk(last_ack - first_v + 1 == len, "R9 one per cycle", 32'(last_ack - first_v + 1), 32'(len));
        @(negedge clk);
        chk(!done, "R10 done single", 32'(done), 0);
        chk(rd_cnt - reads0 == len, "R5 read count", 32'(rd_cnt - reads0), 32'(len));
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(!out_valid && !done, "R12 no second run", 32'({out_valid, done}), 0);
            chk(rd_cnt - reads0 == len, "R12 no extra reads", 32'(rd_cnt - reads0), 32'(len));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int reads0;
        logic [5:0] bad_ops [4];
        bad_ops = '{6'h0E, 6'h00, 6'h3F, 6'h1F};
        repeat (3) @(negedge clk);
        chk(!out_valid && !done && !rf_rd_en, "R1 in reset", 32'({out_valid, done, rf_rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !done && !rf_rd_en, "R1 after reset", 32'({out_valid, done, rf_rd_en}), 0);

        // R2: other opcodes are ignored.
        for (int k = 0; k < 4; k++) begin
            reads0 = rd_cnt;
            instr_valid = 1'b1;
            instr_word  = mk(bad_ops[k], 10'h155, 1'b0, 12'h040);
            xfer_len    = 10'd4;
            out_ack     = 1'b1;
            @(negedge clk);
            instr_valid = 1'b0;
            for (int w = 0; w < 6; w++) begin
                if (out_valid || done) chk(1'b0, "R2 ignored opcode", 32'({out_valid, done}), 0);
                @(negedge clk);
            end
            chk(rd_cnt == reads0, "R2 no reads", 32'(rd_cnt - reads0), 0);
            out_ack = 1'b0;
        end

        // R11: zero length.
        reads0 = rd_cnt;
        instr_valid = 1'b1;
        instr_word  = mk(6'h0F, 10'h2AA, 1'b0, 12'h123);
        xfer_len    = 10'd0;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(done && !out_valid, "R11 done after accept", 32'({done, out_valid}), 32'h2);
        @(negedge clk);
        chk(!done, "R11 done single", 32'(done), 0);
        repeat (3) @(negedge clk);
        chk(rd_cnt == reads0 && !out_valid, "R11 no reads", 32'(rd_cnt - reads0), 0);

        // R4..R10, R8: sweep lengths, sources and acknowledge patterns.
        for (int len = 1; len <= 6; len++) begin
            for (int pat = 0; pat < 4; pat++) begin
                run_xfer(10'(len * 97 + pat), 12'(len * 311 + pat * 1000), len, pat, 1'b0);
            end
        end
        // R4: source index wraps past 4095.
        run_xfer(10'h3FF, 12'hFFD, 7, 0, 1'b0);
        run_xfer(10'h001, 12'hFFE, 5, 3, 1'b0);
        // R12: instruction offered mid-run.
        run_xfer(10'h0C3, 12'h800, 40, 0, 1'b1);
        run_xfer(10'h21A, 12'h4C6, 9, 2, 1'b1);
        // R5: largest length.
        run_xfer(10'h31A, 12'h2C6, 1023, 0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule